// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block lays a 64 by 64 pixel two-plane cursor over the pixel stream that a display controller sends out. Software programs a small set of registers over a write-only port: the cursor bitmap location in memory, the screen position, a hotspot adjustment, two 24-bit colours, an enable bit and the visible screen width. A lock bit lets software change several registers and have them take effect together.

At the start of each line's horizontal blanking the timing generator pulses `line_start` with the number of the coming line. If the cursor covers that line, the block reads the 16-byte bitmap row in two 8-byte beats through a simple read port with one cycle of latency. During the active part of the line every incoming 32-bit pixel passes through a single register stage. Inside the cursor window the pixel is replaced, inverted or left as it is, according to the two plane bits for that position.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `pix_out_valid`, `mix_stall` and `mem_rd_en` are 0. The cursor is disabled and its colours, position and offsets are zero.
- R2: `pix_out`/`pix_out_valid` follow `pix_in`/`pix_valid` one clock later. The pixel is unchanged when the cursor is disabled or the line lies outside Y..Y+63.
- R3: Where the mask-plane bit is 0, the output is `{8'hFF, colour}`, using colour 1 if the image-plane bit is 1 and colour 0 otherwise. Colour writes (select 3 = colour 0, select 4 = colour 1) keep only data bits 23:0.
- R4: Where the mask-plane bit is 1 and the image-plane bit is 1, the output is the bitwise complement of `pix_in`. Where the mask-plane bit is 1 and the image-plane bit is 0, `pix_in` passes unchanged.
- R5: On a `line_start` for a covered line, `mem_rd_en` is high for the next two cycles. The first read is at the row address, which holds the mask plane. The second is at the row address + 8, which holds the image plane. The row address is the base + 16 × (line − Y). Read data returns on the cycle after each read. Byte k of the 64-bit word is bits 8k+7:8k. Cursor pixel p uses byte p/8, bit 7 − (p mod 8).
- R6: Select 0 sets the offset from data bits 26:4 (bits 3:0 read as zero) and the lock from bit 31; all other bits are ignored. Select 2 sets hotspot X from bits 21:16 and hotspot Y from bits 5:0. The base is offset − hotspot X − 16 × hotspot Y, modulo 2^27.
- R7: Select 1 sets X from bits 29:16 and Y from bits 11:0; other bits are ignored. Cursor pixels cover columns X..X+63, and pixels outside that span pass unchanged.
- R8: Select 5 sets enable from bit 0 and the width field W from bits 26:16. Pixels at column ≥ (W+1)×8 pass unchanged and never wrap to another line.
- R9: Register writes take effect two cycles after the write. While the lock is 1, the applied settings stay frozen. Writing the lock to 0 applies every pending value.
- R10: If a cursor pixel arrives before both beats of its row are captured, the pixel passes unchanged and `mix_stall` is 1 with that output. Otherwise `mix_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select (0 offset/lock, 1 position, 2 hotspot, 3 colour 0, 4 colour 1, 5 control) |
| reg_wr_data | input | 32 | Register write data |
| line_start | input | 1 | Pulse at the start of horizontal blanking |
| line_y | input | 12 | Number of the line about to be displayed |
| pix_valid | input | 1 | Incoming pixel valid |
| pix_x | input | 14 | Column of the incoming pixel |
| pix_in | input | 32 | Incoming pixel |
| mem_rd_en | output | 1 | Bitmap read request |
| mem_rd_addr | output | 27 | Bitmap byte address |
| mem_rd_data | input | 64 | Read data, one cycle after the request |
| pix_out_valid | output | 1 | Outgoing pixel valid |
| pix_out | output | 32 | Outgoing pixel |
| mix_stall | output | 1 | Cursor pixel passed through because its row was not yet fetched |

## Verification
The hardest state to reach from the ports is a cursor pixel that arrives while its row fetch is still in flight. A normal timing generator leaves ample blanking time, so that case never happens in ordinary use. The bench creates it by sending a burst of cursor-span pixels right after `line_start`. Every pixel in that burst must pass through with `mix_stall` set, until the cycle after the second beat is captured. The lock window is the other awkward case. Colour and enable changes made while the lock is held must stay invisible in the pixel stream until the lock is written back to zero.

// File: rtl/cursor_pkg.sv
// Shared field widths, register selects and the applied-configuration type
// for the cursor overlay. Assumes a 64x64 cursor held as two 1-bit planes.
package cursor_pkg;
    localparam int OFF_W       = 27;  // cursor memory offset width
    localparam int X_W         = 14;  // column width
    localparam int Y_W         = 12;  // line width
    localparam int HOT_W       = 6;   // hotspot field width
    localparam int COL_W       = 24;  // colour width
    localparam int WF_W        = 11;  // display-width field
    localparam int CUR_DIM     = 64;  // cursor edge in pixels
    localparam int CUR_LOG     = $clog2(CUR_DIM);
    localparam int PLANE_W     = CUR_DIM;      // bits per plane row
    localparam int PLANE_BYTES = PLANE_W / 8;  // byte distance between planes
    localparam int ROW_BYTES   = 2 * PLANE_BYTES;

    typedef struct packed {
        logic               lock;
        logic [OFF_W-1:0]   offset;
        logic [X_W-1:0]     pos_x;
        logic [Y_W-1:0]     pos_y;
        logic [HOT_W-1:0]   hot_x;
        logic [HOT_W-1:0]   hot_y;
        logic [COL_W-1:0]   col0;
        logic [COL_W-1:0]   col1;
        logic               enable;
        logic [WF_W-1:0]    wfield;
    } cur_cfg_t;

    typedef enum logic [2:0] {
        SEL_OFFSET = 3'd0,
        SEL_POS    = 3'd1,
        SEL_HOT    = 3'd2,
        SEL_COL0   = 3'd3,
        SEL_COL1   = 3'd4,
        SEL_CTRL   = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        MIX_PASS, MIX_INVERT, MIX_COL0, MIX_COL1
    } mix_e;
endpackage

// File: rtl/cursor_regs.sv
// Cursor register bank. Writes land in a pending copy; the applied copy
// follows the pending copy each cycle unless the pending lock bit is set.
// Assumes one write per cycle and no read-back path.
module cursor_regs
    import cursor_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output cur_cfg_t    cfg_applied
);
    cur_cfg_t pend_q;
    cur_cfg_t act_q;

    // Decode a write into the pending copy with each field's mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_OFFSET: begin
                    pend_q.lock   <= wr_data[31];
                    pend_q.offset <= {wr_data[OFF_W-1:4], 4'b0000};
                end
                SEL_POS: begin
                    pend_q.pos_x <= wr_data[16 +: X_W];
                    pend_q.pos_y <= wr_data[Y_W-1:0];
                end
                SEL_HOT: begin
                    pend_q.hot_x <= wr_data[16 +: HOT_W];
                    pend_q.hot_y <= wr_data[HOT_W-1:0];
                end
                SEL_COL0: pend_q.col0 <= wr_data[COL_W-1:0];
                SEL_COL1: pend_q.col1 <= wr_data[COL_W-1:0];
                SEL_CTRL: begin
                    pend_q.enable <= wr_data[0];
                    pend_q.wfield <= wr_data[16 +: WF_W];
                end
                default: ;
            endcase
        end
    end

    // Transfer pending state to the applied copy while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!pend_q.lock) begin
            act_q <= pend_q;
        end
    end

    assign cfg_applied = act_q;

    // R9: a held lock freezes the applied settings.
    a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q.lock |=> (act_q == $past(act_q)));
endmodule

// File: rtl/cursor_fetch.sv
// Row fetch engine. On a line-start pulse it decides whether the coming
// line crosses the cursor and, if so, reads the mask plane then the image
// plane in two back-to-back beats. Assumes a read port with a fixed
// one-cycle latency and no back-pressure.
module cursor_fetch
    import cursor_pkg::*;
#(
    parameter int MEM_W = PLANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cur_cfg_t          cfg,
    input  logic              line_start,
    input  logic [Y_W-1:0]    line_y,
    output logic              mem_rd_en,
    output logic [OFF_W-1:0]  mem_rd_addr,
    input  logic [MEM_W-1:0]  mem_rd_data,
    output logic              row_hit,
    output logic              row_ready,
    output logic [MEM_W-1:0]  and_row,
    output logic [MEM_W-1:0]  xor_row
);
    typedef enum logic [1:0] {F_IDLE, F_RD_AND, F_RD_XOR, F_CAP_XOR} fstate_e;

    fstate_e          state_q;
    logic [OFF_W-1:0] addr_q;
    logic [Y_W:0]     rel_line;
    logic             line_hit;
    logic [OFF_W-1:0] base_addr;
    logic [OFF_W-1:0] row_addr;

    // Line coverage test and row address arithmetic.
    always_comb begin
        rel_line  = {1'b0, line_y} - {1'b0, cfg.pos_y};
        line_hit  = cfg.enable && (rel_line[Y_W:CUR_LOG] == '0);
        base_addr = cfg.offset - OFF_W'(cfg.hot_x) - (OFF_W'(cfg.hot_y) << 4);
        row_addr  = base_addr + (OFF_W'(rel_line[CUR_LOG-1:0]) << 4);
    end

    // Fetch sequencer: two read beats, then capture of both planes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= F_IDLE;
            addr_q    <= '0;
            row_hit   <= 1'b0;
            row_ready <= 1'b0;
            and_row   <= '0;
            xor_row   <= '0;
        end else if (line_start) begin
            state_q   <= line_hit ? F_RD_AND : F_IDLE;
            addr_q    <= row_addr;
            row_hit   <= line_hit;
            row_ready <= 1'b0;
        end else begin
            case (state_q)
                F_RD_AND:  state_q <= F_RD_XOR;
                F_RD_XOR: begin
                    and_row <= mem_rd_data;
                    state_q <= F_CAP_XOR;
                end
                F_CAP_XOR: begin
                    xor_row   <= mem_rd_data;
                    row_ready <= 1'b1;
                    state_q   <= F_IDLE;
                end
                default: state_q <= F_IDLE;
            endcase
        end
    end

    // Read request and address for the current beat.
    always_comb begin
        mem_rd_en   = (state_q == F_RD_AND) || (state_q == F_RD_XOR);
        mem_rd_addr = (state_q == F_RD_XOR) ? addr_q + OFF_W'(PLANE_BYTES) : addr_q;
    end

    // R5: the image-plane beat follows the mask-plane beat at +8.
    a_r5_beat_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !$past(mem_rd_en) && !line_start) |=>
            (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + OFF_W'(PLANE_BYTES)));

    // R10: a row is never reported ready while its reads are still issuing.
    a_r10_ready_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        row_ready |-> !mem_rd_en);
endmodule

// File: rtl/cursor_mixer.sv
// Per-pixel mixer. Selects pass, invert or a cursor colour for each
// incoming pixel from the two plane bits, clips at the right screen edge,
// and registers the result. Assumes the colour fills the low COL_W bits
// and that the bits above them form the alpha field.
module cursor_mixer
    import cursor_pkg::*;
#(
    parameter int PIX_W = 32,
    parameter int MEM_W = PLANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cur_cfg_t          cfg,
    input  logic              row_hit,
    input  logic              row_ready,
    input  logic [MEM_W-1:0]  and_row,
    input  logic [MEM_W-1:0]  xor_row,
    input  logic              pix_valid,
    input  logic [X_W-1:0]    pix_x,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out,
    output logic              mix_stall
);
    localparam int ALPHA_W = PIX_W - COL_W;

    logic [X_W:0]       dx;
    logic [X_W:0]       width;
    logic               in_span;
    logic               on_screen;
    logic               draw_zone;
    logic [CUR_LOG-1:0] bit_idx;
    logic               and_bit;
    logic               xor_bit;
    mix_e               mode;
    logic [PIX_W-1:0]   mixed;

    // Window, clip and plane-bit lookup for the current pixel.
    always_comb begin
        dx        = {1'b0, pix_x} - {1'b0, cfg.pos_x};
        in_span   = (dx[X_W:CUR_LOG] == '0);
        width     = ({{(X_W+1-WF_W){1'b0}}, cfg.wfield} + 1'b1) << 3;
        on_screen = ({1'b0, pix_x} < width);
        draw_zone = cfg.enable && row_hit && in_span && on_screen;
        bit_idx   = {dx[CUR_LOG-1:3], ~dx[2:0]};
        and_bit   = and_row[bit_idx];
        xor_bit   = xor_row[bit_idx];
    end

    // Choose the mixing mode from the plane bits.
    always_comb begin
        if (!draw_zone || !row_ready) mode = MIX_PASS;
        else if (and_bit)             mode = xor_bit ? MIX_INVERT : MIX_PASS;
        else                          mode = xor_bit ? MIX_COL1 : MIX_COL0;
    end

    // Form the output pixel for the chosen mode.
    always_comb begin
        case (mode)
            MIX_INVERT: mixed = ~pix_in;
            MIX_COL0:   mixed = {{ALPHA_W{1'b1}}, cfg.col0};
            MIX_COL1:   mixed = {{ALPHA_W{1'b1}}, cfg.col1};
            default:    mixed = pix_in;
        endcase
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out_valid <= 1'b0;
            pix_out       <= '0;
            mix_stall     <= 1'b0;
        end else begin
            pix_out_valid <= pix_valid;
            pix_out       <= mixed;
            mix_stall     <= pix_valid && draw_zone && !row_ready;
        end
    end

    // R2: a disabled cursor leaves the stream untouched.
    a_r2_disabled_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cfg.enable) |=> (pix_out == $past(pix_in)));

    // R8: nothing is drawn at or beyond the display width.
    a_r8_clip_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !on_screen) |=> (pix_out == $past(pix_in)));

    // R10: a stalled pixel is passed through unchanged.
    a_r10_stall_passes: assert property (@(posedge clk) disable iff (!rst_n)
        mix_stall |-> (pix_out == $past(pix_in)));
endmodule

// File: rtl/cursor_overlay.sv
// Top of the cursor overlay: register bank, row fetch engine and pixel
// mixer. Assumes the timing generator pulses line_start early enough in
// blanking for the three-cycle fetch to finish before active pixels.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    input  logic              line_start,
    input  logic [Y_W-1:0]    line_y,
    input  logic              pix_valid,
    input  logic [X_W-1:0]    pix_x,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              mem_rd_en,
    output logic [OFF_W-1:0]  mem_rd_addr,
    input  logic [PLANE_W-1:0] mem_rd_data,
    output logic              pix_out_valid,
    output logic [PIX_W-1:0]  pix_out,
    output logic              mix_stall
);
    cur_cfg_t           cfg;
    logic               row_hit;
    logic               row_ready;
    logic [PLANE_W-1:0] and_row;
    logic [PLANE_W-1:0] xor_row;

    cursor_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_data     (reg_wr_data),
        .cfg_applied (cfg)
    );

    cursor_fetch #(.MEM_W(PLANE_W)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .line_start  (line_start),
        .line_y      (line_y),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .row_hit     (row_hit),
        .row_ready   (row_ready),
        .and_row     (and_row),
        .xor_row     (xor_row)
    );

    cursor_mixer #(.PIX_W(PIX_W), .MEM_W(PLANE_W)) u_mix (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg           (cfg),
        .row_hit       (row_hit),
        .row_ready     (row_ready),
        .and_row       (and_row),
        .xor_row       (xor_row),
        .pix_valid     (pix_valid),
        .pix_x         (pix_x),
        .pix_in        (pix_in),
        .pix_out_valid (pix_out_valid),
        .pix_out       (pix_out),
        .mix_stall     (mix_stall)
    );

    // R1: no read request is issued while reset is applied.
    a_r1_no_read_in_reset: assert property (@(posedge clk)
        !rst_n |=> !mem_rd_en);
endmodule

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        line_start = 1'b0;
    logic [11:0] line_y = '0;
    logic        pix_valid = 1'b0;
    logic [13:0] pix_x = '0;
    logic [31:0] pix_in = '0;
    logic        mem_rd_en;
    logic [26:0] mem_rd_addr;
    logic [63:0] mem_rd_data = '0;
    logic        pix_out_valid;
    logic [31:0] pix_out;
    logic        mix_stall;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] membytes [0:4095];

    // Pending and applied register model
    int p_lock = 0, p_off = 0, p_px = 0, p_py = 0, p_hx = 0, p_hy = 0;
    int p_c0 = 0, p_c1 = 0, p_en = 0, p_wf = 0;
    int a_off = 0, a_px = 0, a_py = 0, a_hx = 0, a_hy = 0;
    int a_c0 = 0, a_c1 = 0, a_en = 0, a_wf = 0;
    int cur_y = 0;

    cursor_overlay u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .line_start(line_start), .line_y(line_y),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out), .mix_stall(mix_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: 8 little-endian bytes, one cycle latency
    always @(posedge clk) begin
        if (mem_rd_en) begin
            for (int b = 0; b < 8; b++)
                mem_rd_data[8*b +: 8] <= membytes[(int'(mem_rd_addr) + b) & 4095];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [26:0] row_base(input int y);
        logic [26:0] base;
        base = 27'(a_off - a_hx - 16 * a_hy);
        return base + 27'((y - a_py) * 16);
    endfunction

    function automatic bit line_covered(input int y);
        return (a_en != 0) && (y >= a_py) && (y <= a_py + 63);
    endfunction

    function automatic logic [31:0] exp_pix(input int x, input int y, input logic [31:0] pin,
                                            output string tag);
        int dx, ra, bi;
        logic [7:0] ab, xb;
        if (!line_covered(y)) begin tag = "R2"; return pin; end
        dx = x - a_px;
        if (dx < 0 || dx > 63) begin tag = "R7"; return pin; end
        if (x >= (a_wf + 1) * 8) begin tag = "R8"; return pin; end
        ra = int'(row_base(y));
        ab = membytes[(ra + dx / 8) & 4095];
        xb = membytes[(ra + 8 + dx / 8) & 4095];
        bi = 7 - (dx % 8);
        if (ab[bi]) begin tag = "R4"; return xb[bi] ? ~pin : pin; end
        tag = "R3";
        return {8'hFF, xb[bi] ? 24'(a_c1) : 24'(a_c0)};
    endfunction

    // Register write; waits until the value would be applied (R9 model)
    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 3'(sel); reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        case (sel)
            0: begin p_lock = int'(d[31]); p_off = int'(d[26:4]) * 16; end
            1: begin p_px = int'(d[29:16]); p_py = int'(d[11:0]); end
            2: begin p_hx = int'(d[21:16]); p_hy = int'(d[5:0]); end
            3: p_c0 = int'(d[23:0]);
            4: p_c1 = int'(d[23:0]);
            5: begin p_en = int'(d[0]); p_wf = int'(d[26:16]); end
            default: ;
        endcase
        @(posedge clk); #1;
        if (p_lock == 0) begin
            a_off = p_off; a_px = p_px; a_py = p_py; a_hx = p_hx; a_hy = p_hy;
            a_c0 = p_c0; a_c1 = p_c1; a_en = p_en; a_wf = p_wf;
        end
    endtask

    // Line start with fetch checks, then wait until the row is ready
    task automatic start_line(input int y);
        logic [26:0] ea;
        bit hit;
        hit = line_covered(y);
        ea = row_base(y);
        cur_y = y;
        @(negedge clk);
        line_start = 1'b1; line_y = 12'(y);
        @(posedge clk); #1;
        line_start = 1'b0;
        if (hit) begin
            chk(mem_rd_en && mem_rd_addr == ea, "R5 mask beat", {36'b0, mem_rd_addr}, {36'b0, ea});
            @(posedge clk); #1;
            chk(mem_rd_en && mem_rd_addr == ea + 27'd8, "R5 image beat", {36'b0, mem_rd_addr}, {36'b0, ea + 27'd8});
            @(posedge clk); #1;
            chk(!mem_rd_en, "R5 two beats only", {63'b0, mem_rd_en}, 64'd0);
        end else begin
            chk(!mem_rd_en, "R2 no fetch on uncovered line", {63'b0, mem_rd_en}, 64'd0);
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    task automatic px(input int x, input logic [31:0] pin, input string over);
        string tag;
        logic [31:0] e;
        e = exp_pix(x, cur_y, pin, tag);
        if (over != "") tag = over;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = 14'(x); pix_in = pin;
        @(posedge clk); #1;
        chk(pix_out_valid && pix_out == e && !mix_stall, tag, {31'b0, mix_stall, pix_out}, {32'b0, e});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 4096; i++) membytes[i] = 8'($urandom);
        // Directed row at 0x100: p0 col0, p1 col1, p2 invert, p3 transparent
        membytes[12'h100] = 8'b0011_0101;
        membytes[12'h108] = 8'b0110_1100;

        repeat (3) @(posedge clk);
        #1;
        chk(!pix_out_valid && !mix_stall && !mem_rd_en, "R1 reset outputs",
            {61'b0, pix_out_valid, mix_stall, mem_rd_en}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!mem_rd_en && !pix_out_valid, "R1 idle after reset", {62'b0, mem_rd_en, pix_out_valid}, 64'd0);
        cur_y = 10;
        px(5, 32'h1234_5678, "R1");

        // Directed setup with noise in ignored bits
        wr(0, 32'h7000_010F);                    // offset 0x100 (R6)
        wr(1, (32'd100 << 16) | 32'd50 | 32'hC000_F000); // X=100 Y=50 (R7)
        wr(3, 32'hAB12_3456);                    // colour 0 -> 0x123456 (R3)
        wr(4, 32'hCD65_4321);                    // colour 1 -> 0x654321 (R3)
        wr(5, (32'd79 << 16) | 32'd1);           // enable, width 640
        start_line(49);
        px(100, 32'hDEAD_BEEF, "R2");
        start_line(50);
        px(100, 32'h0102_0304, "R3");
        px(101, 32'h0102_0304, "R3");
        px(102, 32'h0F0F_F0F0, "R4");
        px(103, 32'h0F0F_F0F0, "R4");
        for (int x = 96; x < 168; x++) px(x, $urandom, "");
        start_line(114);
        px(110, 32'h5555_AAAA, "R2");

        // Disable then check pass-through on covered line
        wr(5, (32'd79 << 16));
        start_line(60);
        px(120, 32'h7777_7777, "R2");
        wr(5, (32'd79 << 16) | 32'd1);

        // Hotspot address arithmetic
        wr(2, (32'd5 << 16) | 32'd2 | 32'hFFC0_FFC0);
        start_line(51);
        for (int x = 100; x < 110; x++) px(x, $urandom, "R6");
        wr(2, 32'd0);

        // Right-edge clip
        wr(1, (32'd600 << 16) | 32'd50);
        start_line(70);
        for (int x = 628; x < 670; x++) px(x, $urandom, "");

        // Lock window
        wr(1, (32'd100 << 16) | 32'd50);
        wr(0, 32'h8000_0100);
        wr(3, 32'h0000_FF00);
        wr(5, 32'd0);
        start_line(50);
        px(100, 32'h1111_1111, "R9 locked colour");
        wr(0, 32'h0000_0100);
        start_line(50);
        px(100, 32'h1111_1111, "R9 unlocked colour");
        px(101, 32'h2222_2222, "R9 unlocked enable");
        wr(5, (32'd79 << 16) | 32'd1);

        // Late fetch: pixels right after line start must stall (R10)
        cur_y = 50;
        @(negedge clk);
        line_start = 1'b1; line_y = 12'd50;
        @(posedge clk); #1;
        line_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            logic [31:0] pin, e;
            string tag;
            pin = $urandom;
            e = exp_pix(100 + k, 50, pin, tag);
            @(negedge clk);
            pix_valid = 1'b1; pix_x = 14'(100 + k); pix_in = pin;
            @(posedge clk); #1;
            if (k < 2)
                chk(mix_stall && pix_out == pin, "R10 stall pass", {31'b0, mix_stall, pix_out}, {32'b1, pin});
            else if (k >= 3)
                chk(!mix_stall && pix_out == e, "R10 mixed once ready", {31'b0, mix_stall, pix_out}, {32'b0, e});
        end

        // Random configurations and lines
        for (int it = 0; it < 20; it++) begin
            int ly;
            wr(0, ($urandom & 32'h7800_000F) | ((32'h400 + ($urandom % 64) * 16)));
            wr(1, (($urandom % 700) << 16) | ($urandom % 200) | ($urandom & 32'hC000_F000));
            wr(2, $urandom);
            wr(3, $urandom);
            wr(4, $urandom);
            wr(5, ((32'd40 + $urandom % 50) << 16) | 32'd1 | ($urandom & 32'hF800_FFFE));
            ly = a_py - 4 + int'($urandom % 74);
            if (ly < 0) ly = 0;
            start_line(ly);
            for (int j = 0; j < 24; j++) begin
                int x;
                x = a_px - 8 + int'($urandom % 80);
                if (x < 0) x = 0;
                px(x, $urandom, "");
            end
        end

        @(negedge clk);
        pix_valid = 1'b0;
        @(posedge clk); #1;
        chk(!pix_out_valid, "R2 valid follows input", {63'b0, pix_out_valid}, 64'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule